// File: doc/BRIEF.md
# E1 CRC4 Multiframe Alignment Controller

This block follows an E1 basic frame aligner. Once per 125 µs frame it receives a strobe, together with a flag that says whether basic (two-frame) alignment is held. On non-FAS frames it also receives the bit that carries the CRC4 multiframe alignment signal. It collects those bits, looks for the six-bit multiframe pattern, and declares multiframe alignment once two matches are seen a whole number of 2 ms periods apart.

The search runs inside a timer window of 64 frames that floats. The window starts when basic alignment is gained. Each pattern match reloads it to 48 frames. If the window runs out, the block raises an expiry pulse. If forced resynchronisation is enabled, it also raises a request for a fresh basic alignment search.

With interworking enabled, the block may go 3200 frames in search with basic alignment held and still not find multiframe alignment. It then declares the far end to be non-CRC4 and stops searching. Loss of basic alignment always returns the block to its idle hunt state.

Top module: `e1_mfa_ctrl`

## Requirements
- R1: After reset, `lmfa` is 1 and `mfa_rec`, `win_exp`, `rsync_req` and `non_crc4` are 0.
- R2: Multiframe alignment is declared when a second pattern match arrives exactly 16·n frame strobes after the reference match (n ≥ 1, within the window). At that point `lmfa` falls, and `mfa_rec` is high for exactly one clock in the cycle after that strobe.
- R3: A frame is a pattern candidate only when `frm_stb` and `frm_odd` are both 1. The pattern is 001011, with the first bit received leftmost. It is matched over `mf_bit` of six consecutive odd frames, the current frame supplying the last bit.
- R4: A match whose distance from the reference is not a multiple of 16 frames does not declare alignment. That match becomes the new reference.
- R5: Entering search (basic alignment gained) loads a 64-frame window. With no match, `win_exp` pulses for one clock after the 64th strobe, and then every further 64 strobes.
- R6: A match that does not confirm alignment reloads the window to 48 frames. If no confirmation follows, `win_exp` pulses after the 48th strobe that comes after the match.
- R7: `rsync_req` pulses together with `win_exp` when `auto_rsync_en` is 1, and stays 0 when it is 0.
- R8: With `iw_en` = 1, the 3200th strobe in search without alignment sets `non_crc4`. That strobe produces no `win_exp`, and later matches are ignored. With `iw_en` = 0, `non_crc4` stays 0.
- R9: Once aligned, `mf_bit` content is not checked, and `lmfa` stays 0 while `dfa_ok` is held.
- R10: `dfa_ok` = 0 on any clock sets `lmfa` to 1 and clears `non_crc4` at the next edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_stb | input | 1 | One-clock strobe per received frame |
| frm_odd | input | 1 | Current frame is a non-FAS frame |
| mf_bit | input | 1 | Multiframe alignment bit of the current frame |
| dfa_ok | input | 1 | Basic frame alignment held |
| auto_rsync_en | input | 1 | Request a new basic search on window expiry |
| iw_en | input | 1 | Enable the non-CRC4 interworking timeout |
| lmfa | output | 1 | Loss of multiframe alignment |
| mfa_rec | output | 1 | One-clock pulse when alignment is recovered |
| win_exp | output | 1 | One-clock window expiry pulse |
| rsync_req | output | 1 | One-clock request for a new basic alignment search |
| non_crc4 | output | 1 | Far end treated as non-CRC4 |

## Verification
The assertions take it as given that `frm_stb` is a single-clock pulse and that `frm_odd` alternates between frames while `dfa_ok` is held. They also assume that basic alignment loss is signalled only through `dfa_ok`. The stimulus drives exactly one clock of strobe per frame, with idle clocks only around alignment loss, and keeps odd and even frames alternating. Filler frames carry all ones on odd positions, so a pattern match can occur only where the bench places one. Even-frame bits and the offsets and spacings of the patterns are drawn at random.

// File: rtl/e1_mfa_ctrl.sv
module e1_mfa_ctrl #(
  parameter int FPM    = 16,
  parameter int WIN_FR = 64,
  parameter int REM_FR = 48,
  parameter int IW_FR  = 3200,
  parameter logic [5:0] PAT = 6'b001011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_stb,
  input  logic frm_odd,
  input  logic mf_bit,
  input  logic dfa_ok,
  input  logic auto_rsync_en,
  input  logic iw_en,
  output logic lmfa,
  output logic mfa_rec,
  output logic win_exp,
  output logic rsync_req,
  output logic non_crc4
);
  localparam int TW  = $clog2(WIN_FR + 1);
  localparam int IWW = $clog2(IW_FR + 1);
  localparam int PW  = $clog2(FPM);

  typedef enum logic [1:0] {HUNT, SRCH, SYNC, NOCRC} st_t;

  st_t            st;
  logic [4:0]     sh;
  logic [TW-1:0]  tmr;
  logic [IWW-1:0] iwc;
  logic [PW-1:0]  ph;
  logic           have;

  wire hit     = frm_stb && frm_odd && ({sh, mf_bit} == PAT);
  wire confirm = hit && have && (ph == '0);

  assign lmfa     = (st != SYNC);
  assign non_crc4 = (st == NOCRC);

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else if (frm_stb && frm_odd) sh <= {sh[3:0], mf_bit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT; tmr <= '0; iwc <= '0; ph <= '0; have <= 1'b0;
      mfa_rec <= 1'b0; win_exp <= 1'b0; rsync_req <= 1'b0;
    end else begin
      mfa_rec <= 1'b0; win_exp <= 1'b0; rsync_req <= 1'b0;
      if (!dfa_ok) st <= HUNT;
      else case (st)
        HUNT: begin
          st <= SRCH; tmr <= TW'(WIN_FR); have <= 1'b0; iwc <= '0;
        end
        SRCH: if (frm_stb) begin
          ph <= (ph == PW'(FPM - 1)) ? '0 : ph + 1'b1;
          if (iwc != IWW'(IW_FR - 1)) iwc <= iwc + 1'b1;
          if (confirm) begin
            st <= SYNC; mfa_rec <= 1'b1;
          end else if (iw_en && iwc == IWW'(IW_FR - 1)) begin
            st <= NOCRC;
          end else if (hit) begin
            have <= 1'b1; ph <= PW'(1); tmr <= TW'(REM_FR);
          end else if (tmr == TW'(1)) begin
            win_exp <= 1'b1; rsync_req <= auto_rsync_en;
            have <= 1'b0; tmr <= TW'(WIN_FR);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_REC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    mfa_rec |-> !lmfa && $past(lmfa)); // R2
  AST_SYNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lmfa && dfa_ok) |=> !lmfa); // R9
  AST_EXP_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    win_exp |=> !win_exp); // R5
  AST_EXP_IN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    win_exp |-> lmfa && !non_crc4); // R5
  AST_RSYNC_WITH_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    rsync_req |-> win_exp && $past(auto_rsync_en)); // R7
  AST_NOCRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (non_crc4 && dfa_ok) |=> non_crc4 && lmfa); // R8
  AST_LOSS_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !dfa_ok |=> lmfa && !non_crc4 && !mfa_rec); // R10
endmodule

// File: tb/e1_mfa_ctrl_tb.sv
module e1_mfa_ctrl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, frm_stb = 1'b0, frm_odd = 1'b0, mf_bit = 1'b0;
  logic dfa_ok = 1'b0, auto_rsync_en = 1'b0, iw_en = 1'b0;
  logic lmfa, mfa_rec, win_exp, rsync_req, non_crc4;

  e1_mfa_ctrl u_dut (.clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_odd(frm_odd),
    .mf_bit(mf_bit), .dfa_ok(dfa_ok), .auto_rsync_en(auto_rsync_en), .iw_en(iw_en),
    .lmfa(lmfa), .mfa_rec(mfa_rec), .win_exp(win_exp), .rsync_req(rsync_req),
    .non_crc4(non_crc4));

  localparam logic [5:0] PATB = 6'b001011;
  int n_chk = 0, n_fail = 0;
  int gfc, n_t8, n_rs, n_rec, first_t8, last_t8, rec_at;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(bit odd, bit b);
    frm_stb = 1'b1; frm_odd = odd; mf_bit = b;
    @(negedge clk);
    frm_stb = 1'b0; gfc++;
    if (win_exp) begin n_t8++; if (first_t8 < 0) first_t8 = gfc; last_t8 = gfc; end
    if (rsync_req) n_rs++;
    if (mfa_rec) begin n_rec++; rec_at = gfc; end
  endtask

  task automatic bad(int n);
    for (int i = 0; i < n; i++) frame(i[0], i[0] ? 1'b1 : 1'($urandom % 2));
  endtask

  task automatic noisy(int n);
    for (int i = 0; i < n; i++) frame(i[0], 1'($urandom % 2));
  endtask

  function automatic bit mf_val(int k);
    if (!k[0]) return 1'($urandom % 2);
    if ((k - 1) / 2 < 6) return PATB[5 - (k - 1) / 2];
    return 1'b1;
  endfunction

  task automatic good_mf();
    for (int k = 0; k < 16; k++) frame(k[0], mf_val(k));
  endtask

  task automatic restart(string req);
    dfa_ok = 1'b0;
    @(negedge clk);
    chk({req, " lmfa on loss"}, lmfa, 1);
    chk({req, " non_crc4 on loss"}, non_crc4, 0);
    dfa_ok = 1'b1;
    @(negedge clk);
    gfc = 0; n_t8 = 0; n_rs = 0; n_rec = 0; first_t8 = -1; last_t8 = -1; rec_at = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 lmfa", lmfa, 1);
    chk("R1 mfa_rec", mfa_rec, 0);
    chk("R1 win_exp", win_exp, 0);
    chk("R1 rsync_req", rsync_req, 0);
    chk("R1 non_crc4", non_crc4, 0);
    rst_n = 1'b1;
    @(negedge clk);

    restart("R10");
    good_mf();
    chk("R3 single pattern no sync", lmfa, 1);
    good_mf();
    chk("R2 sync after two patterns", lmfa, 0);
    chk("R2 recovery pulse frame", rec_at, 28);
    chk("R2 recovery pulse count", n_rec, 1);

    noisy(48);
    chk("R9 sync kept with random bits", lmfa, 0);
    chk("R9 no extra recovery", n_rec, 1);

    restart("R10");
    good_mf();
    bad(8);
    good_mf();
    chk("R4 distance 24 no sync", lmfa, 1);
    good_mf();
    chk("R4 new reference confirms", lmfa, 0);

    restart("R10");
    bad(130);
    chk("R5 first expiry frame", first_t8, 64);
    chk("R5 expiry recurs", last_t8, 128);
    chk("R5 expiry count", n_t8, 2);
    chk("R7 no request when disabled", n_rs, 0);

    restart("R10");
    good_mf();
    bad(60);
    chk("R6 expiry 48 after match", first_t8, 60);
    chk("R6 expiry count", n_t8, 1);

    auto_rsync_en = 1'b1;
    restart("R10");
    bad(64);
    chk("R7 request count", n_rs, 1);
    chk("R7 request with expiry", first_t8, 64);
    auto_rsync_en = 1'b0;

    iw_en = 1'b1;
    restart("R10");
    bad(3199);
    chk("R8 not yet non-CRC4", non_crc4, 0);
    bad(1);
    chk("R8 non-CRC4 at 3200", non_crc4, 1);
    chk("R8 expiries before timeout", n_t8, 49);
    good_mf();
    good_mf();
    chk("R8 patterns ignored", lmfa, 1);
    chk("R8 no recovery", n_rec, 0);
    chk("R8 stays non-CRC4", non_crc4, 1);
    restart("R10 from non-CRC4");
    iw_en = 1'b0;
    bad(3300);
    chk("R8 disabled no fallback", non_crc4, 0);
    chk("R8 disabled still searching", lmfa, 1);

    for (int it = 0; it < 16; it++) begin
      int k, n;
      k = $urandom % 16;
      n = 1 + ($urandom % 4);
      restart("R10");
      bad(k);
      good_mf();
      bad(16 * (n - 1));
      good_mf();
      chk($sformatf("R2 R6 random n=%0d lmfa", n), lmfa, (n > 3) ? 1 : 0);
      chk($sformatf("R6 random n=%0d expiries", n), n_t8, (n > 3) ? 1 : 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule